// File: doc/BRIEF.md
# Streaming Byte Descrambler

This block sits on the byte stream that leaves a disc reader and undoes the scrambling applied to the data. Each accepted byte passes through up to three transforms: an XOR with one key byte, a left rotate by a programmable distance, and a swap of its two nibbles. One bit of a control byte enables each transform on its own. The stream enters and leaves with a valid/ready handshake. One register stage lies between the two sides. Backpressure reaches the input in the same cycle.

Fifteen key bytes are held in three blocks of five. A validity byte marks which blocks are in use, and a mask byte hides the key values. When a key byte is read back or used by the datapath, it is XORed with the mask byte if its block is marked valid. Otherwise the raw value is returned. The stored key bytes are never changed by this unmasking. All of these values are reached through a byte-wide write/read bus.

Top module: `byte_descrambler`

## Requirements
- R1: After a synchronous reset, out_valid is 0, in_ready is 1, and every key byte, the validity byte, the mask byte and the control byte read back as 0x00.
- R2: Register map on cfg_addr: addresses 0..14 hold the key bytes, where block = address / 5 and the byte within the block = address % 5. Address 15 holds the validity byte, 16 the mask byte and 17 the control byte. A read of any other address returns 0x00, and a write to any other address changes nothing. cfg_rdata shows the value at cfg_addr one clock after the address is applied.
- R3: When control bit 0 is 1, each byte is XORed with key byte 4 (block 0, byte 4), after that key byte has been unmasked.
- R4: When control bit 1 is 1, each byte is rotated left by control bits 6:4. Control bit 7 is ignored, so a distance of 0 or 8 leaves the byte unchanged.
- R5: When control bit 3 is 1, the high and low nibbles of each byte are swapped.
- R6: Control bit 2 has no effect on the data. With bits 0, 1 and 3 all 0, out_data equals the accepted input byte.
- R7: When more than one transform is enabled, they apply in this order: XOR first, then rotate, then nibble swap.
- R8: Bits 2:0 of the validity byte mark key blocks 2..0 as valid. A key byte in a valid block reads back, and is used, XORed with the mask byte. A key byte in an invalid block reads back and is used as stored. Validity bits 7:3 are not stored and read as 0.
- R9: Unmasking never overwrites the stored key. When a block's validity bit is cleared, its raw bytes read back again.
- R10: A byte accepted on a clock edge (in_valid and in_ready both 1) appears on out_data with out_valid=1 right after that edge. in_ready equals (not out_valid) or out_ready. While out_valid=1 and out_ready=0, out_data holds its value.
- R11: With out_ready held at 1, back-to-back input bytes come out on consecutive cycles with no empty cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register address |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Registered read data for cfg_addr |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can take an input byte |
| in_data | input | 8 | Scrambled input byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream can take the output byte |
| out_data | output | 8 | Descrambled output byte |

## Verification
A wrong control or key register shows up on out_data in the first byte accepted after the fault, one clock after acceptance. Key readback exposes it one clock after the address is presented. A corrupted unmasking path shows at once as a wrong readback of a valid block, and the raw-value readback after clearing a validity bit would show a key that had been overwritten. A pipeline state fault, such as a lost hold during a stall or an inserted bubble, is seen within one cycle on out_valid or out_data.

// File: rtl/dscr_pkg.sv
package dscr_pkg;
  localparam int DATA_W      = 8;
  localparam int KEY_BLOCKS  = 3;
  localparam int BLOCK_BYTES = 5;
  localparam int KEY_BYTES   = KEY_BLOCKS * BLOCK_BYTES;
  localparam int ADDR_W      = 5;
  localparam int KIDX_W      = $clog2(KEY_BYTES);
  localparam int XOR_KEY_IDX = 4;

  localparam logic [ADDR_W-1:0] ADDR_VALID = ADDR_W'(KEY_BYTES);
  localparam logic [ADDR_W-1:0] ADDR_MASK  = ADDR_W'(KEY_BYTES + 1);
  localparam logic [ADDR_W-1:0] ADDR_CTRL  = ADDR_W'(KEY_BYTES + 2);

  typedef struct packed {
    logic [3:0] shift_amt;
    logic       swap_en;
    logic       spare;
    logic       rot_en;
    logic       xor_en;
  } ctrl_t;
endpackage

// File: rtl/dscr_key_bank.sv
module dscr_key_bank
  import dscr_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata,
  output logic [DATA_W-1:0]   use_key,
  output ctrl_t               ctrl
);
  logic [DATA_W-1:0]     raw_q [KEY_BYTES];
  logic [KEY_BLOCKS-1:0] valid_q;
  logic [DATA_W-1:0]     mask_q;
  ctrl_t                 ctrl_q;
  logic [DATA_W-1:0]     view [KEY_BYTES];

  wire is_key = (addr < ADDR_VALID);
  wire [KIDX_W-1:0] kidx = addr[KIDX_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < KEY_BYTES; k++) raw_q[k] <= '0;
      valid_q <= '0;
      mask_q  <= '0;
      ctrl_q  <= '0;
    end else if (we) begin
      if (is_key) raw_q[kidx] <= wdata;
      else if (addr == ADDR_VALID) valid_q <= wdata[KEY_BLOCKS-1:0];
      else if (addr == ADDR_MASK)  mask_q  <= wdata;
      else if (addr == ADDR_CTRL)  ctrl_q  <= wdata;
    end
  end

  // unmasked view: computed from raw storage, storage itself untouched
  for (genvar b = 0; b < KEY_BLOCKS; b++) begin : g_blk
    for (genvar i = 0; i < BLOCK_BYTES; i++) begin : g_byte
      assign view[b*BLOCK_BYTES+i] =
        raw_q[b*BLOCK_BYTES+i] ^ (valid_q[b] ? mask_q : '0);
    end
  end

  assign use_key = view[XOR_KEY_IDX];
  assign ctrl    = ctrl_q;

  logic [DATA_W-1:0] rd_next;
  always_comb begin
    rd_next = '0;
    if (is_key)                  rd_next = view[kidx];
    else if (addr == ADDR_VALID) rd_next = DATA_W'(valid_q);
    else if (addr == ADDR_MASK)  rd_next = mask_q;
    else if (addr == ADDR_CTRL)  rd_next = ctrl_q;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end
endmodule

// File: rtl/dscr_xform.sv
module dscr_xform
  import dscr_pkg::*;
(
  input  logic [DATA_W-1:0] din,
  input  logic [DATA_W-1:0] key,
  input  ctrl_t             ctrl,
  output logic [DATA_W-1:0] dout
);
  localparam int SH_W = $clog2(DATA_W);

  logic [DATA_W-1:0]   s_xor, s_rot;
  logic [2*DATA_W-1:0] dbl;
  logic [SH_W-1:0]     amt;

  assign s_xor = ctrl.xor_en ? (din ^ key) : din;
  assign amt   = ctrl.shift_amt[SH_W-1:0];
  assign dbl   = {s_xor, s_xor} << amt;
  assign s_rot = ctrl.rot_en ? dbl[2*DATA_W-1:DATA_W] : s_xor;
  assign dout  = ctrl.swap_en ? {s_rot[DATA_W/2-1:0], s_rot[DATA_W-1:DATA_W/2]}
                              : s_rot;
endmodule

// File: rtl/dscr_stage.sv
module dscr_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         s_valid,
  output logic         s_ready,
  input  logic [W-1:0] s_data,
  output logic         m_valid,
  input  logic         m_ready,
  output logic [W-1:0] m_data
);
  assign s_ready = !m_valid || m_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      m_valid <= 1'b0;
      m_data  <= '0;
    end else if (s_ready) begin
      m_valid <= s_valid;
      if (s_valid) m_data <= s_data;
    end
  end
endmodule

// File: rtl/byte_descrambler.sv
module byte_descrambler
  import dscr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [4:0]        cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data
);
  ctrl_t             ctrl;
  logic [DATA_W-1:0] use_key;
  logic [DATA_W-1:0] xf_data;

  dscr_key_bank u_keys (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .use_key(use_key), .ctrl(ctrl)
  );

  dscr_xform u_xf (
    .din(in_data), .key(use_key), .ctrl(ctrl), .dout(xf_data)
  );

  dscr_stage #(.W(DATA_W)) u_stage (
    .clk(clk), .rst(rst),
    .s_valid(in_valid), .s_ready(in_ready), .s_data(xf_data),
    .m_valid(out_valid), .m_ready(out_ready), .m_data(out_data)
  );
endmodule

// File: rtl/byte_descrambler_chk.sv
module byte_descrambler_chk (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       in_ready,
  input logic [7:0] in_data,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic [7:0] ctrl_b
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> !out_valid);

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R11
  accept_out_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  // R6
  passthru_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && (ctrl_b & 8'h0B) == 8'h00)
      |=> (out_data == $past(in_data)));

  // R5
  swap_only_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && (ctrl_b & 8'h0B) == 8'h08)
      |=> (out_data == {$past(in_data[3:0]), $past(in_data[7:4])}));
endmodule

bind byte_descrambler byte_descrambler_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .ctrl_b(ctrl)
);

// File: tb/byte_descrambler_tb_top.sv
module byte_descrambler_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [4:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  byte_descrambler dut_i (.*);

  // {ctrl, din, expected}; key byte 4 unmasks to 0xA5 during this table
  localparam logic [23:0] VEC [9] = '{
    {8'h00, 8'h12, 8'h12},   // R6 all off
    {8'h01, 8'h12, 8'hB7},   // R3 xor 0xA5
    {8'h32, 8'h81, 8'h0C},   // R4 rotl 3
    {8'h08, 8'h12, 8'h21},   // R5 swap
    {8'h04, 8'h12, 8'h12},   // R6 bit2 inert
    {8'h1B, 8'h12, 8'hF6},   // R7 xor,rot1,swap
    {8'h82, 8'h96, 8'h96},   // R4 amount 8
    {8'hF2, 8'h01, 8'h80},   // R4 amount 15 -> 7
    {8'h30, 8'h81, 8'h81}    // R4 rotate disabled
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [4:0] a, input logic [7:0] exp);
    @(negedge clk);
    cfg_addr = a;
    @(negedge clk);
    chk(req, cfg_rdata, exp);
  endtask

  task automatic send_chk(input string req, input logic [7:0] d, input logic [7:0] exp);
    @(negedge clk);
    in_valid = 1'b1; in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " valid"}, {7'd0, out_valid}, 8'd1);
    chk(req, out_data, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 out_valid", {7'd0, out_valid}, 8'd0);
    chk("R1 in_ready", {7'd0, in_ready}, 8'd1);
    rd_chk("R1 ctrl", 5'd17, 8'h00);
    rd_chk("R1 key4", 5'd4, 8'h00);
    rd_chk("R1 mask", 5'd16, 8'h00);

    // R2 / R8 key setup and readback
    wr(5'd4, 8'h5A);
    wr(5'd15, 8'h01);
    wr(5'd16, 8'hFF);
    rd_chk("R8 key4 unmasked", 5'd4, 8'hA5);
    rd_chk("R2 valid readback", 5'd15, 8'h01);

    // table walk
    for (int k = 0; k < 9; k++) begin
      wr(5'd17, VEC[k][23:16]);
      send_chk($sformatf("R3-7 vec%0d", k), VEC[k][15:8], VEC[k][7:0]);
    end

    // R9 raw value returns when validity cleared; R8 invalid key used raw
    wr(5'd15, 8'h00);
    rd_chk("R9 key4 raw", 5'd4, 8'h5A);
    wr(5'd17, 8'h01);
    send_chk("R8 raw key xor", 8'h12, 8'h48);

    // R8 other blocks
    wr(5'd5, 8'h11);
    wr(5'd14, 8'h30);
    wr(5'd15, 8'hFA);  // bits 1 only among 2:0 -> 010
    rd_chk("R8 block1 valid", 5'd5, 8'hEE);
    rd_chk("R8 block0 invalid", 5'd4, 8'h5A);
    rd_chk("R8 block2 invalid", 5'd14, 8'h30);
    rd_chk("R8 upper bits", 5'd15, 8'h02);
    wr(5'd15, 8'h04);
    rd_chk("R8 block2 valid", 5'd14, 8'hCF);

    // R2 unmapped address
    wr(5'd20, 8'hFF);
    rd_chk("R2 unmapped read", 5'd20, 8'h00);
    rd_chk("R2 ctrl untouched", 5'd17, 8'h01);

    // R10 backpressure
    wr(5'd17, 8'h00);
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_data = 8'hAA;
    @(negedge clk);
    chk("R10 first out", out_data, 8'hAA);
    chk("R10 in_ready low", {7'd0, in_ready}, 8'd0);
    in_data = 8'h55;
    @(negedge clk);
    chk("R10 hold", out_data, 8'hAA);
    out_ready = 1'b1;
    @(negedge clk);
    chk("R10 after release", out_data, 8'h55);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R10 drained", {7'd0, out_valid}, 8'd0);

    // R11 back-to-back
    @(negedge clk);
    in_valid = 1'b1; in_data = 8'h10;
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      chk("R11 valid", {7'd0, out_valid}, 8'd1);
      chk("R11 data", out_data, 8'(8'h10 + k - 1));
      if (k < 4) in_data = 8'(8'h10 + k);
      else in_valid = 1'b0;
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule